// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Generator

This block produces one pulse-width-modulated output from a single free-running 8-bit counter. Software sets it up through two byte-wide registers behind a plain address/write-strobe port. A control register holds an enable flag and a two-bit period select. A duty register holds a 7-bit compare threshold. The period select fixes the number of counter states in one period at 128 >> select. This gives 128, 64, 32 or 16 steps, so a higher select gives a faster period with coarser steps.

The counter advances once for each cycle in which the tick enable input is high. The output is high while the counter's low bits, masked to the active period width, are below the duty threshold. Writes take effect at once. A new duty value changes the very next compare. Changing the period select does not restart the counter. Because the duty field has only 7 bits, a 100% duty cycle is out of reach when the select is 0. When the enable flag is clear, the pin carries a separate general-purpose output value instead, and the counter keeps running.

Top module: `pwm_tick_gen`

## Requirements
- R1: After reset, both registers read 0, the counter is 0 and the pin equals `gpio_val`. Reset is asserted asynchronously and released two clock cycles after `rst_n` rises.
- R2: A write with `bus_wr` high at a rising edge goes to the control register when `bus_addr` is 0 and to the duty register when `bus_addr` is 1. Control keeps bit 7 (enable) and bits 1:0 (period select). Duty keeps bits 6:0. Bits that are not kept read as 0.
- R3: `bus_rdata` shows the register selected by `bus_addr` in the same cycle, without waiting for a clock edge.
- R4: The counter increments by one (mod 256) at each rising edge where `tick_en` is high, and holds its value otherwise.
- R5: While enabled, `pwm_out` is 1 exactly when (counter mod (128 >> select)) < duty.
- R6: Writing a new period select does not alter the counter value.
- R7: A new duty value governs `pwm_out` from the cycle right after the write.
- R8: With a nonzero select and duty ≥ the period length, `pwm_out` stays high for the whole period.
- R9: With select 0 and the largest duty (127), `pwm_out` is low for exactly one of every 128 ticks.
- R10: While disabled, `pwm_out` equals `gpio_val`, and the counter keeps advancing on `tick_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tick_en | input | 1 | Counter advance enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 duty |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| gpio_val | input | 1 | Fallback pin value while disabled |
| pwm_out | output | 1 | Pin output |

## Verification
A long random run mixes an irregular `tick_en` pattern with occasional register writes to random addresses and data. Each cycle it compares the pin against a bench model of counter, registers and mask. This separates a wrong mask width from a wrong counter step and from a counter that restarts on a select write. Directed cases then cover the two duty extremes. Duty 64 at select 1 must never go low. Duty 127 at select 0 must give exactly one low tick per period. The disabled case toggles `gpio_val` and then re-enables, which shows whether the counter kept running.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_DUTY = 1'b1
  } pwm_reg_e;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_tick_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2,
  parameter int DUTY_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic [SEL_W-1:0]  sel,
  output logic [DUTY_W-1:0] duty
);
  localparam int EN_BIT = DATA_W - 1;

  logic              en_q, en_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic              wr_ctrl, wr_duty;

  always_comb begin
    wr_ctrl = wr && (pwm_reg_e'(addr) == REG_CTRL);
    wr_duty = wr && (pwm_reg_e'(addr) == REG_DUTY);
    en_d    = wr_ctrl ? wdata[EN_BIT]      : en_q;
    sel_d   = wr_ctrl ? wdata[SEL_W-1:0]   : sel_q;
    duty_d  = wr_duty ? wdata[DUTY_W-1:0]  : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      duty_q <= '0;
    end else begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      duty_q <= duty_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (pwm_reg_e'(addr) == REG_CTRL) begin
      rdata[EN_BIT]    = en_q;
      rdata[SEL_W-1:0] = sel_q;
    end else begin
      rdata[DUTY_W-1:0] = duty_q;
    end
  end

  assign en   = en_q;
  assign sel  = sel_q;
  assign duty = duty_q;

  // R2 / R7: a duty write lands one edge later; otherwise duty holds
  a_r7_duty_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_duty |=> (duty_q == $past(wdata[DUTY_W-1:0])));
  a_r2_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr) |=> $stable(duty_q));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = tick_en ? cnt_q + CNT_W'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R4: step by one on tick, hold otherwise
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W  = 8,
  parameter int SEL_W  = 2,
  parameter int DUTY_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DUTY_W-1:0] duty,
  input  logic              gpio_val,
  output logic              pin
);
  localparam int TOP_EXP = CNT_W - 1;

  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] phase;
  logic             below;

  always_comb begin
    span  = CNT_W'(1) << (TOP_EXP - int'(sel));
    mask  = span - CNT_W'(1);
    phase = cnt & mask;
    below = phase < CNT_W'(duty);
    pin   = en ? below : gpio_val;
  end

  // R8: duty at or above a short period keeps the pin high
  a_r8_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (sel != '0) && (CNT_W'(duty) >= span)) |-> pin);
  // R9: select 0, last phase of the period is always low
  a_r9_last_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (sel == '0) && (cnt[TOP_EXP-1:0] == '1)) |-> !pin);
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int SEL_W  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              gpio_val,
  output logic              pwm_out
);
  localparam int DUTY_W = CNT_W - 1;

  logic              rst_n_i;
  logic              en;
  logic [SEL_W-1:0]  sel;
  logic [DUTY_W-1:0] duty;
  logic [CNT_W-1:0]  cnt;

  pwm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  pwm_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W), .DUTY_W(DUTY_W)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .en(en), .sel(sel), .duty(duty)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .tick_en(tick_en), .cnt(cnt)
  );

  pwm_compare #(.CNT_W(CNT_W), .SEL_W(SEL_W), .DUTY_W(DUTY_W)) u_cmp (
    .clk(clk), .rst_n(rst_n_i), .cnt(cnt), .en(en), .sel(sel),
    .duty(duty), .gpio_val(gpio_val), .pin(pwm_out)
  );

  // R6: a control write leaves the counter on its normal step
  a_r6_sel_no_restart: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bus_wr && !bus_addr && tick_en) |=> (cnt == $past(cnt) + CNT_W'(1)));
  // R10: disabled pin follows the fallback input
  a_r10_fallback: assert property (@(posedge clk) disable iff (!rst_n_i)
    !en |-> (pwm_out == gpio_val));
endmodule

// File: tb/pwm_tick_gen_test.sv
`timescale 1ns/1ps
module pwm_tick_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, bus_wr, bus_addr, gpio_val;
  logic [7:0] bus_wdata, bus_rdata;
  logic       pwm_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_cnt, m_sel, m_duty;
  bit m_en;

  always #2.5 clk = ~clk;

  pwm_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_val(gpio_val), .pwm_out(pwm_out)
  );

  function automatic bit exp_pin(int c, bit e, int s, int d, bit g);
    int msk = (1 << (7 - s)) - 1;
    if (!e) return g;
    return ((c & msk) < d);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    if (bus_wr) begin
      if (!bus_addr) begin m_en = bus_wdata[7]; m_sel = bus_wdata[1:0]; end
      else m_duty = bus_wdata[6:0];
    end
    if (tick_en) m_cnt = (m_cnt + 1) % 256;
    @(negedge clk);
  endtask

  task automatic chk_pin(string tag);
    chk(tag, pwm_out, exp_pin(m_cnt, m_en, m_sel, m_duty, gpio_val));
  endtask

  task automatic wr_reg(bit a, logic [7:0] d, string tag);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cyc();
    bus_wr = 1'b0;
    chk_pin(tag);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lows;
    void'($urandom(32'd2024));
    rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0;
    bus_wdata = '0; gpio_val = 1'b0;
    m_cnt = 0; m_sel = 0; m_duty = 0; m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_addr = 1'b0; #0.1 chk("R1 ctrl", bus_rdata, 0);
    bus_addr = 1'b1; #0.1 chk("R1 duty", bus_rdata, 0);
    gpio_val = 1'b1; #0.1 chk("R1 pin", pwm_out, 1);
    gpio_val = 1'b0; #0.1 chk("R1 pin", pwm_out, 0);

    // R2 / R3 readback masking
    wr_reg(1'b0, 8'h7C, "R2");
    bus_addr = 1'b0; #0.1 chk("R2 ctrl reserved", bus_rdata, 8'h00);
    wr_reg(1'b1, 8'hFF, "R2");
    bus_addr = 1'b1; #0.1 chk("R2 duty", bus_rdata, 8'h7F);
    wr_reg(1'b0, 8'hFE, "R2");
    bus_addr = 1'b0; #0.1 chk("R3 ctrl", bus_rdata, 8'h82);
    bus_addr = 1'b1; #0.1 chk("R3 duty", bus_rdata, 8'h7F);

    // R8 select 1, duty 64: never low
    wr_reg(1'b1, 8'd64, "R8");
    wr_reg(1'b0, 8'h81, "R8");
    tick_en = 1'b1; lows = 0;
    for (int i = 0; i < 128; i++) begin
      cyc(); if (!pwm_out) lows++;
    end
    chk("R8 lows", lows, 0);

    // R9 select 0, duty 127: one low per 128 ticks
    wr_reg(1'b1, 8'd127, "R9");
    wr_reg(1'b0, 8'h80, "R9");
    lows = 0;
    for (int i = 0; i < 128; i++) begin
      cyc(); if (!pwm_out) lows++;
    end
    chk("R9 lows", lows, 1);

    // R7 duty takes effect next cycle; R6 select change keeps count
    wr_reg(1'b1, 8'd10, "R7");
    wr_reg(1'b1, 8'd90, "R7");
    wr_reg(1'b0, 8'h83, "R6");
    for (int i = 0; i < 20; i++) begin cyc(); chk_pin("R6"); end
    wr_reg(1'b0, 8'h80, "R6");
    for (int i = 0; i < 20; i++) begin cyc(); chk_pin("R6"); end

    // R4 hold when tick_en low
    tick_en = 1'b0;
    wr_reg(1'b1, 8'd40, "R4");
    for (int i = 0; i < 10; i++) begin cyc(); chk_pin("R4 hold"); end

    // R10 disabled: pin = gpio_val, counter runs
    wr_reg(1'b0, 8'h02, "R10");
    tick_en = 1'b1;
    for (int i = 0; i < 37; i++) begin
      gpio_val = i[0];
      cyc(); chk("R10 pin", pwm_out, gpio_val);
    end
    wr_reg(1'b0, 8'h82, "R10");
    for (int i = 0; i < 32; i++) begin cyc(); chk_pin("R10 resume"); end

    // R5 random mix
    for (int i = 0; i < 4000; i++) begin
      tick_en = ($urandom % 4) != 0;
      gpio_val = $urandom % 2;
      bus_wr = ($urandom % 16) == 0;
      bus_addr = $urandom % 2;
      bus_wdata = 8'($urandom);
      if (($urandom % 4) == 0) bus_wdata[7] = 1'b1;
      cyc();
      bus_wr = 1'b0;
      chk_pin("R5");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule